// File: doc/BRIEF.md
# Flow-Control XOFF Retransmit Scheduler

This block decides when the transmit side of an Ethernet MAC must emit flow-control frames. It watches one standard PAUSE request and eight per-priority (PFC) requests. The first cycle a request is seen high, an XOFF is scheduled for that queue. While the request stays high, the XOFF is sent again each time the queue's holdoff timer runs out. When the request drops, one XON is scheduled, carrying quanta 0, and that queue's timer stops.

The timers advance on a quantum tick input, where one quantum is 512 bit times. Three holdoff modes are selected at run time. In per-queue mode each queue has its own timer. In uniform mode a shared free-running timer also triggers expiry, so each queue is re-sent after the shorter of the two intervals. This lets several PFC queues land in the same frame. In off mode no retransmission happens.

The output is a held frame request: a queue mask plus one quanta field per queue. It stays stable until the downstream frame builder acknowledges it. Events that occur while a request is held are collected and sent in the next request.

Top module: `fc_xoff_sched`

## Requirements
- R1: After reset `frmValid` is 0 and `frmMask` is 0.
- R2: A request that goes from 0 to 1 produces a frame request two clock edges later. The mask bit is set for that queue (bits 0..7 = PFC priorities 0..7, bit 8 = standard PAUSE). Its quanta field holds the queue's programmed XOFF quanta.
- R3: While `frmValid` is 1 and `frmAck` is 0, the mask and all quanta fields remain unchanged. An edge with `frmAck` high clears `frmValid` at that edge.
- R4: A request that goes from 1 to 0 produces exactly one XON for that queue, with quanta 0. Its holdoff timer stops, so later ticks send nothing more for it.
- R5: In per-queue mode (`holdMode`=0), after an XOFF is acknowledged with the request still high, the XOFF is re-sent on the H-th following tick and not before. H is the queue's holdoff.
- R6: In uniform mode (`holdMode`=1), a shared timer counts every tick from reset and expires on every U-th tick. A queue waiting on retransmission then expires on the first of its own H-th tick and the shared expiry. All queues expiring together appear in one frame request.
- R7: In off mode (`holdMode`=2 or 3), no XOFF is re-sent while a request stays high. XOFF on rise and XON on fall still occur.
- R8: A PAUSE event (mask bit 8) is always sent alone in its own frame request. It is sent before pending PFC events, which follow in the next request.
- R9: Events arising while a frame request is held are merged into the next request. This includes XOFFs and XONs for different queues.
- R10: Quanta for queue i occupy `frmQuanta[16*i+15:16*i]`. Fields of queues not in the mask are 0.
- R11: Holdoff timers advance only on edges where `quantumTick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| quantumTick | input | 1 | One-cycle pulse per pause quantum |
| holdMode | input | 2 | 0 per-queue, 1 uniform, 2/3 off |
| pauseReq | input | 1 | Standard PAUSE request level |
| pfcReq | input | 8 | Per-priority PFC request levels |
| frmAck | input | 1 | Frame builder accepted the held request |
| frmValid | output | 1 | Frame request held |
| frmMask | output | 9 | Queues included (bit 8 = PAUSE) |
| frmQuanta | output | 144 | Per-queue quanta, 16 bits each |

## Verification
The hardest behaviour to reach is uniform-mode expiry. The shared timer's phase depends on every tick issued since reset, not on the current test. The bench therefore routes all ticks through one task that counts them. It derives the distance to the next shared expiry from that count. It then stops one tick short, checks that nothing was emitted, and issues the final tick. The same method checks the case where a short per-queue holdoff beats the shared timer. A held request is also kept unacknowledged while several queues rise and fall, to show that the events merge into the next request.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  localparam int NUM_PFC   = 8;
  localparam int NUM_Q     = NUM_PFC + 1;
  localparam int PAUSE_IDX = NUM_PFC;
  localparam int QUANTA_W  = 16;

  typedef logic [NUM_Q-1:0][QUANTA_W-1:0] qvec_t;

  localparam logic [1:0] HOLD_PERQ = 2'd0;
  localparam logic [1:0] HOLD_UNI  = 2'd1;

  typedef struct packed {
    logic             load;
    logic [NUM_Q-1:0] loadMask;
    logic [NUM_Q-1:0] loadXoff;
    logic [NUM_Q-1:0] restart;
    logic [NUM_Q-1:0] stop;
  } ctlStrobe_t;
endpackage

// File: rtl/fc_timer_dp.sv
module fc_timer_dp
  import flowctl_pkg::*;
#(
  parameter qvec_t                HOLD_Q   = {NUM_Q{16'd32768}},
  parameter qvec_t                QUANTA_Q = {NUM_Q{16'd65535}},
  parameter logic [QUANTA_W-1:0]  UNI_HOLD = 16'd32768
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tick,
  input  logic [1:0]                mode,
  input  ctlStrobe_t                strb,
  output logic [NUM_Q-1:0]          expire,
  output logic [NUM_Q*QUANTA_W-1:0] quantaOut
);
  localparam logic [QUANTA_W-1:0] UNI_LAST = UNI_HOLD - 1'b1;

  logic [QUANTA_W-1:0] uniCnt;
  logic                uniHit;
  logic                modeOff;
  logic                modeUni;

  assign uniHit  = tick && (uniCnt == UNI_LAST);
  assign modeOff = mode[1];
  assign modeUni = (mode == HOLD_UNI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     uniCnt <= '0;
    else if (tick) uniCnt <= uniHit ? '0 : uniCnt + 1'b1;
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    localparam logic [QUANTA_W-1:0] LAST = HOLD_Q[q] - 1'b1;
    logic                running;
    logic [QUANTA_W-1:0] cnt;
    logic                ownHit;

    assign ownHit    = tick && (cnt == LAST);
    assign expire[q] = running && (ownHit || (modeUni && uniHit));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (strb.stop[q] || modeOff) begin
        running <= 1'b0;
      end else if (strb.restart[q]) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (expire[q]) begin
        running <= 1'b0;
      end else if (running && tick) begin
        cnt <= cnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        quantaOut[q*QUANTA_W +: QUANTA_W] <= '0;
      else if (strb.load)
        quantaOut[q*QUANTA_W +: QUANTA_W] <=
          (strb.loadMask[q] && strb.loadXoff[q]) ? QUANTA_Q[q] : '0;
    end
  end
endmodule

// File: rtl/fc_sched_ctl.sv
module fc_sched_ctl
  import flowctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_Q-1:0] reqNow,
  input  logic [NUM_Q-1:0] expire,
  input  logic             ack,
  output ctlStrobe_t       strb,
  output logic             frmValid,
  output logic [NUM_Q-1:0] frmMask
);
  localparam logic [NUM_Q-1:0] PAUSE_BIT = NUM_Q'(1) << PAUSE_IDX;

  logic [NUM_Q-1:0] prevReq, rise, fall;
  logic [NUM_Q-1:0] pendOn, pendOff, pendOnN, pendOffN, pend;
  logic [NUM_Q-1:0] selMask, frmXoff;
  logic             latch, done;

  assign rise    = reqNow & ~prevReq;
  assign fall    = ~reqNow & prevReq;
  assign pend    = pendOn | pendOff;
  assign selMask = pend[PAUSE_IDX] ? PAUSE_BIT : (pend & ~PAUSE_BIT);
  assign latch   = !frmValid && (|selMask);
  assign done    = frmValid && ack;

  always_comb begin
    pendOnN  = pendOn;
    pendOffN = pendOff;
    if (latch) begin
      pendOnN  = pendOnN & ~selMask;
      pendOffN = pendOffN & ~selMask;
    end
    pendOnN  = (pendOnN & ~fall) | rise | (expire & reqNow);
    pendOffN = (pendOffN & ~rise) | fall;
  end

  always_comb begin
    strb.load     = latch;
    strb.loadMask = selMask;
    strb.loadXoff = selMask & pendOn;
    strb.restart  = done ? (frmMask & frmXoff & reqNow) : '0;
    strb.stop     = fall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevReq  <= '0;
      pendOn   <= '0;
      pendOff  <= '0;
      frmValid <= 1'b0;
      frmMask  <= '0;
      frmXoff  <= '0;
    end else begin
      prevReq <= reqNow;
      pendOn  <= pendOnN;
      pendOff <= pendOffN;
      if (latch) begin
        frmValid <= 1'b1;
        frmMask  <= selMask;
        frmXoff  <= selMask & pendOn;
      end else if (done) begin
        frmValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fc_xoff_sched.sv
module fc_xoff_sched
  import flowctl_pkg::*;
#(
  parameter qvec_t               HOLD_Q   = {NUM_Q{16'd32768}},
  parameter qvec_t               QUANTA_Q = {NUM_Q{16'd65535}},
  parameter logic [QUANTA_W-1:0] UNI_HOLD = 16'd32768
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      quantumTick,
  input  logic [1:0]                holdMode,
  input  logic                      pauseReq,
  input  logic [NUM_PFC-1:0]        pfcReq,
  input  logic                      frmAck,
  output logic                      frmValid,
  output logic [NUM_Q-1:0]          frmMask,
  output logic [NUM_Q*QUANTA_W-1:0] frmQuanta
);
  ctlStrobe_t       strb;
  logic [NUM_Q-1:0] expire;

  fc_sched_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqNow   ({pauseReq, pfcReq}),
    .expire   (expire),
    .ack      (frmAck),
    .strb     (strb),
    .frmValid (frmValid),
    .frmMask  (frmMask)
  );

  fc_timer_dp #(
    .HOLD_Q   (HOLD_Q),
    .QUANTA_Q (QUANTA_Q),
    .UNI_HOLD (UNI_HOLD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (quantumTick),
    .mode      (holdMode),
    .strb      (strb),
    .expire    (expire),
    .quantaOut (frmQuanta)
  );
endmodule

// File: rtl/fc_xoff_sched_chk.sv
module fc_xoff_sched_chk
  import flowctl_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      frmAck,
  input logic                      frmValid,
  input logic [NUM_Q-1:0]          frmMask,
  input logic [NUM_Q*QUANTA_W-1:0] frmQuanta
);
  // R1: first edge after reset release sees an idle output
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !frmValid);

  // R3: held request is frozen until acknowledged
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmAck) |=> (frmValid && $stable(frmMask) && $stable(frmQuanta)));

  // R3: acknowledge releases the request
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmAck) |=> !frmValid);

  // R8: PAUSE travels alone; a request never has an empty mask
  p_pause_alone_r8: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> (frmMask[PAUSE_IDX] ? $onehot0(frmMask) : (|frmMask)));

  // R10: fields of absent queues are zero
  for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
      (frmValid && !frmMask[q]) |-> (frmQuanta[q*QUANTA_W +: QUANTA_W] == '0));
  end
endmodule

bind fc_xoff_sched fc_xoff_sched_chk u_chk (.*);

// File: tb/sim_fc_xoff_sched.sv
module sim_fc_xoff_sched;
  import flowctl_pkg::*;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic                      quantumTick = 1'b0;
  logic [1:0]                holdMode = 2'd0;
  logic                      pauseReq = 1'b0;
  logic [NUM_PFC-1:0]        pfcReq = '0;
  logic                      frmAck = 1'b0;
  logic                      frmValid;
  logic [NUM_Q-1:0]          frmMask;
  logic [NUM_Q*QUANTA_W-1:0] frmQuanta;

  int checks = 0;
  int errors = 0;
  int tickCount = 0;
  localparam int UHOLD = 6;

  fc_xoff_sched #(
    .HOLD_Q   ({16'd20, 16'd24, 16'd22, 16'd20, 16'd18, 16'd16, 16'd14, 16'd12, 16'd3}),
    .QUANTA_Q ({16'hFFFF, 16'h1107, 16'h1106, 16'h1105, 16'h1104,
                16'h1103, 16'h1102, 16'h1101, 16'h1100}),
    .UNI_HOLD (16'd6)
  ) u0 (.*);

  always #10 clk = ~clk;

  function automatic logic [15:0] qExp(int i);
    return (i == PAUSE_IDX) ? 16'hFFFF : 16'h1100 + 16'(i);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkFrm(string tag, logic [NUM_Q-1:0] m);
    chk(tag, {22'd0, frmValid, frmMask}, {22'd0, 1'b1, m});
  endtask

  task automatic chkIdle(string tag);
    chk(tag, {31'd0, frmValid}, 32'd0);
  endtask

  task automatic slot(string tag, int i, logic [15:0] e);
    chk(tag, {16'd0, frmQuanta[i*16 +: 16]}, {16'd0, e});
  endtask

  task automatic ackFrm();
    frmAck = 1'b1;
    cyc(1);
    frmAck = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      quantumTick = 1'b1;
      cyc(1);
      quantumTick = 1'b0;
      tickCount++;
    end
  endtask

  task automatic drain();
    pfcReq = '0;
    pauseReq = 1'b0;
    for (int i = 0; i < 12; i++) begin
      cyc(1);
      if (frmValid) ackFrm();
    end
  endtask

  task automatic t_reset();
    chkIdle("R1 valid after reset");
    chk("R1 mask after reset", {23'd0, frmMask}, 32'd0);
  endtask

  task automatic t_perq();
    holdMode = 2'd0;
    pfcReq[2] = 1'b1;
    cyc(2);
    chkFrm("R2 xoff on rise", 9'h004);
    slot("R2 xoff quanta", 2, qExp(2));
    ackFrm();
    cyc(30);
    chkIdle("R11 no expiry without ticks");
    ticks(13);
    cyc(1);
    chkIdle("R5 no resend before holdoff");
    ticks(1);
    cyc(1);
    chkFrm("R5 resend at holdoff", 9'h004);
    slot("R5 resend quanta", 2, qExp(2));
    ackFrm();
    pfcReq[2] = 1'b0;
    cyc(2);
    chkFrm("R4 xon on fall", 9'h004);
    slot("R4 xon quanta zero", 2, 16'h0);
    ackFrm();
    ticks(40);
    cyc(1);
    chkIdle("R4 single xon and timer stopped");
  endtask

  task automatic t_uniform();
    int r, n;
    holdMode = 2'd1;
    pfcReq[1] = 1'b1;
    pfcReq[3] = 1'b1;
    cyc(2);
    chkFrm("R6 initial pair", 9'h00A);
    ackFrm();
    r = UHOLD - (tickCount % UHOLD);
    ticks(r - 1);
    cyc(1);
    chkIdle("R6 before shared expiry");
    ticks(1);
    cyc(1);
    chkFrm("R6 batched resend", 9'h00A);
    slot("R6 batched quanta q1", 1, qExp(1));
    slot("R6 batched quanta q3", 3, qExp(3));
    drain();
    pfcReq[0] = 1'b1;
    cyc(2);
    chkFrm("R6 q0 xoff", 9'h001);
    ackFrm();
    r = UHOLD - (tickCount % UHOLD);
    n = (r < 3) ? r : 3;
    ticks(n - 1);
    cyc(1);
    chkIdle("R6 before shorter expiry");
    ticks(1);
    cyc(1);
    chkFrm("R6 shorter of two timers", 9'h001);
    drain();
  endtask

  task automatic t_off();
    holdMode = 2'd2;
    pfcReq[5] = 1'b1;
    cyc(2);
    chkFrm("R7 xoff on rise", 9'h020);
    ackFrm();
    ticks(40);
    cyc(1);
    chkIdle("R7 no resend in off mode");
    pfcReq[5] = 1'b0;
    cyc(2);
    chkFrm("R7 xon in off mode", 9'h020);
    slot("R7 xon quanta", 5, 16'h0);
    ackFrm();
    holdMode = 2'd0;
  endtask

  task automatic t_pause();
    pauseReq = 1'b1;
    pfcReq[4] = 1'b1;
    cyc(2);
    chkFrm("R8 pause alone first", 9'h100);
    slot("R8 pause quanta", 8, qExp(8));
    ackFrm();
    chkIdle("R3 ack clears valid");
    cyc(1);
    chkFrm("R8 pfc follows", 9'h010);
    slot("R10 pfc quanta slot4", 4, qExp(4));
    ackFrm();
    drain();
  endtask

  task automatic t_merge();
    pfcReq[6] = 1'b1;
    cyc(2);
    chkFrm("R9 first frame", 9'h040);
    pfcReq[7] = 1'b1;
    pfcReq[2] = 1'b1;
    cyc(1);
    pfcReq[6] = 1'b0;
    cyc(5);
    chkFrm("R3 held frame unchanged", 9'h040);
    slot("R3 held quanta unchanged", 6, qExp(6));
    ackFrm();
    cyc(1);
    chkFrm("R9 merged next frame", 9'h0C4);
    slot("R10 slot2 xoff", 2, qExp(2));
    slot("R10 slot6 xon", 6, 16'h0);
    slot("R10 slot7 xoff", 7, qExp(7));
    slot("R10 slot0 unused", 0, 16'h0);
    ackFrm();
    drain();
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_perq();
    t_uniform();
    t_off();
    t_pause();
    t_merge();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule